// File: doc/BRIEF.md
# Serial EEPROM Burst Write Sequencer

This block writes a run of 16-bit words into a serial EEPROM that speaks the common four-wire SPI command set. A client hands over a starting word offset and a word count with a one-cycle request, then supplies each data word when the block pulls it. The block checks the request against the device size and asks a shared-bus arbiter for the pins. It then drives chip select, serial clock and data out itself, and reads the device's data-out line while it polls status.

Each page burst begins with a status poll that repeats until the device reports ready. A write-enable command follows, and then a write command carrying the opcode, the byte address and the data. A burst that reaches the end of a device page closes the command and opens a new poll/enable/write cycle for the words that remain. When the run finishes, or when a step fails after the bus was requested, the block releases the pins and the request line. It reports completion with a one-cycle done pulse, and an error flag rides on that pulse when the run failed.

Top module: `spi_eeprom_writer`

## Requirements
- R1: A request whose offset is at least WORD_SIZE, whose count is zero, or whose count is larger than WORD_SIZE minus the offset ends with done and error together. The bus request line never rises and chip select never goes low for such a request.
- R2: After a valid request, `bus_req` is raised and `bus_gnt` is sampled once per cycle for at most GRANT_TRIES cycles. A grant seen on the last try is accepted. With no grant, the run ends with an error and `bus_req` drops in the same cycle that done pulses, without chip select going low.
- R3: A ready poll is one command: opcode 0x05, then 8 status bits shifted in. The device is ready when the last bit received (status bit 0) is 0, and the other status bits are ignored. A busy answer triggers a chip-select pulse and another poll, up to READY_TRIES polls per page. If no poll reports ready, the run ends with an error and the bus is released.
- R4: Each write command is preceded by a separate write-enable command with opcode 0x06. The two are separated by a chip-select high pulse.
- R5: A write command sends opcode 0x02 and then the byte address, which is the word offset times two, in ADDR_BITS bits sent MSB first. When ADDR_BITS is 8 and the starting offset is 128 or more, every write command of the run carries opcode 0x0A, meaning bit 3 is set as the ninth address bit. The address field is the low 8 bits of the byte address.
- R6: Each data word is pulled with a one-cycle `word_take` and is sent as two bytes, low byte first, each byte MSB first. Exactly the requested number of words is pulled.
- R7: After a word whose following byte address is a multiple of PAGE_BYTES, the write command is closed. If words remain, a new poll, enable and write command follows. A command never carries data bytes on both sides of a page boundary.
- R8: Data out changes only while the serial clock is low and is held stable while it is high. The serial clock pulses only while chip select is low. Data out is low after the last bit of a transfer and whenever chip select is high.
- R9: At the end of every run, chip select is high, `bus_req` is low and `done` is high for exactly one cycle. `error` is high only in a cycle where `done` is high.
- R10: During and right after reset, chip select is high, clock and data out are low, `bus_req` and `done` are low, and `start_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | One-cycle request to begin a write run |
| start_ready | output | 1 | High while idle and able to take a request |
| start_offset | input | OFF_W+1 | First device word to write |
| start_count | input | CNT_W | Number of words to write |
| word_data | input | 16 | Next data word, valid when word_take is high |
| word_take | output | 1 | Pulls the current data word |
| bus_req | output | 1 | Request for the shared serial pins |
| bus_gnt | input | 1 | Grant of the shared serial pins |
| spi_cs_n | output | 1 | Device select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | Run failed, valid with done |

## Verification
The bench models the device at the pin level and sends status bytes whose upper bits are set, so a design that tested any status bit other than bit 0 would never see ready. Runs that straddle page boundaries and word 128 expose a design that forgets to reopen the command, sends a wrong address, or drops the ninth-address flag. The grant and ready limits are each hit exactly at the last allowed try and one past it, which catches off-by-one retry counters. Bounds requests at the very end of the device, and just past it, show whether a rejected request still disturbs the pins.

// File: rtl/spi_ew_pkg.sv
package spi_ew_pkg;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_HIADR = 8'h08;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_GRANT,
    ST_POLL_OP,
    ST_POLL_RD,
    ST_WREN,
    ST_WROP,
    ST_ADDR,
    ST_DATA,
    ST_PULSE,
    ST_RELEASE
  } ew_state_t;
endpackage

// File: rtl/spi_ew_rst_sync.sv
module spi_ew_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/spi_ew_bounds.sv
module spi_ew_bounds #(
  parameter int WORD_SIZE = 256,
  parameter int OFF_W     = 8,
  parameter int CNT_W     = 9
) (
  input  logic [OFF_W:0]   offset,
  input  logic [CNT_W-1:0] count,
  output logic             bad,
  output logic             upper_half
);
  localparam int XW = ((OFF_W + 2) > CNT_W) ? (OFF_W + 2) : CNT_W + 1;
  localparam logic [XW-1:0] WS_X  = XW'(WORD_SIZE);
  localparam logic [XW-1:0] HALF8 = XW'(128);

  logic [XW-1:0] off_x, cnt_x, room_x;

  always_comb begin
    off_x      = XW'(offset);
    cnt_x      = XW'(count);
    room_x     = WS_X - off_x;
    bad        = (off_x >= WS_X) || (cnt_x == '0) || (cnt_x > room_x);
    upper_half = (off_x >= HALF8);
  end
endmodule

// File: rtl/spi_ew_cmdgen.sv
module spi_ew_cmdgen
  import spi_ew_pkg::*;
#(
  parameter int OFF_W      = 8,
  parameter int ADDR_BITS  = 8,
  parameter int PAGE_BYTES = 16
) (
  input  logic [OFF_W-1:0]     cur_word,
  input  logic                 fold_hi,
  output logic [ADDR_BITS-1:0] byte_addr,
  output logic [7:0]           wr_opcode,
  output logic                 page_end
);
  localparam int BW   = OFF_W + 1;
  localparam int PG_W = $clog2(PAGE_BYTES);

  logic [BW-1:0]   ba;
  logic [PG_W-1:0] next_low;

  assign ba = {cur_word, 1'b0};

  generate
    if (ADDR_BITS <= BW) begin : g_trunc
      assign byte_addr = ba[ADDR_BITS-1:0];
    end else begin : g_extend
      assign byte_addr = {{(ADDR_BITS-BW){1'b0}}, ba};
    end
  endgenerate

  always_comb begin
    next_low  = ba[PG_W-1:0] + PG_W'(2);
    page_end  = (next_low == '0);
    wr_opcode = OP_WRITE | (fold_hi ? OP_HIADR : 8'h00);
  end
endmodule

// File: rtl/spi_ew_shifter.sv
module spi_ew_shifter #(
  parameter int CLK_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] tx_word,
  input  logic [4:0]  nbits,
  input  logic        miso,
  output logic        busy,
  output logic        done,
  output logic        rx_bit,
  output logic        sck,
  output logic        mosi
);
  localparam int DV_W = $clog2(CLK_DIV + 1);

  logic            busy_q, busy_d, phase_q, phase_d, rx_q, rx_d, done_q, done_d;
  logic [DV_W-1:0] div_q, div_d;
  logic [4:0]      bit_q, bit_d, nb_q, nb_d;
  logic [15:0]     sreg_q, sreg_d;
  logic            tick, en;

  always_comb begin
    tick    = busy_q && (div_q == DV_W'(CLK_DIV - 1));
    en      = start || busy_q;
    busy_d  = busy_q;
    phase_d = phase_q;
    rx_d    = rx_q;
    div_d   = div_q;
    bit_d   = bit_q;
    nb_d    = nb_q;
    sreg_d  = sreg_q;
    done_d  = 1'b0;
    if (start && !busy_q) begin
      busy_d  = 1'b1;
      phase_d = 1'b0;
      div_d   = '0;
      bit_d   = '0;
      nb_d    = nbits;
      sreg_d  = tx_word << (5'd16 - nbits);
    end else if (busy_q) begin
      if (tick) begin
        div_d = '0;
        if (!phase_q) begin
          phase_d = 1'b1;
          rx_d    = miso;
        end else begin
          phase_d = 1'b0;
          sreg_d  = {sreg_q[14:0], 1'b0};
          if (bit_q == nb_q - 5'd1) begin
            busy_d = 1'b0;
            done_d = 1'b1;
          end else begin
            bit_d = bit_q + 5'd1;
          end
        end
      end else begin
        div_d = div_q + DV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      rx_q    <= 1'b0;
      done_q  <= 1'b0;
      div_q   <= '0;
      bit_q   <= '0;
      nb_q    <= '0;
      sreg_q  <= '0;
    end else begin
      done_q <= done_d;
      if (en) begin
        busy_q  <= busy_d;
        phase_q <= phase_d;
        rx_q    <= rx_d;
        div_q   <= div_d;
        bit_q   <= bit_d;
        nb_q    <= nb_d;
        sreg_q  <= sreg_d;
      end
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign rx_bit = rx_q;
  assign sck    = phase_q;
  assign mosi   = busy_q & sreg_q[15];
endmodule

// File: rtl/spi_eeprom_writer.sv
module spi_eeprom_writer
  import spi_ew_pkg::*;
#(
  parameter int WORD_SIZE   = 256,
  parameter int ADDR_BITS   = 8,
  parameter int PAGE_BYTES  = 16,
  parameter int CLK_DIV     = 2,
  parameter int GRANT_TRIES = 16,
  parameter int READY_TRIES = 6,
  parameter int OFF_W       = $clog2(WORD_SIZE),
  parameter int CNT_W       = $clog2(WORD_SIZE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid,
  output logic             start_ready,
  input  logic [OFF_W:0]   start_offset,
  input  logic [CNT_W-1:0] start_count,
  input  logic [15:0]      word_data,
  output logic             word_take,
  output logic             bus_req,
  input  logic             bus_gnt,
  output logic             spi_cs_n,
  output logic             spi_sck,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             done,
  output logic             error
);
  localparam int  TR_W = $clog2(GRANT_TRIES + 1);
  localparam int  PL_W = $clog2(READY_TRIES + 1);
  localparam int  DV_W = $clog2(CLK_DIV + 1);
  localparam bit  FOLD = (ADDR_BITS == 8);

  logic rst_n_s;
  ew_state_t state_q, state_d, ret_q, ret_d;
  logic             sent_q, sent_d, hi_q, hi_d, err_q, err_d;
  logic             cs_q, cs_d, req_q, req_d, done_q, done_d, error_q, error_d;
  logic [TR_W-1:0]  tries_q, tries_d;
  logic [PL_W-1:0]  polls_q, polls_d;
  logic [DV_W-1:0]  pcnt_q, pcnt_d;
  logic [OFF_W-1:0] cur_q, cur_d;
  logic [CNT_W-1:0] remain_q, remain_d;

  logic        sh_start, sh_busy, sh_done, sh_rx;
  logic [15:0] sh_tx;
  logic [4:0]  sh_nbits;
  logic        req_bad, req_hi, page_end, take;
  logic [ADDR_BITS-1:0] byte_addr;
  logic [7:0]  wr_op;

  spi_ew_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s));

  spi_ew_bounds #(.WORD_SIZE(WORD_SIZE), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_bounds (
    .offset(start_offset), .count(start_count), .bad(req_bad), .upper_half(req_hi));

  spi_ew_cmdgen #(.OFF_W(OFF_W), .ADDR_BITS(ADDR_BITS), .PAGE_BYTES(PAGE_BYTES)) u_cmd (
    .cur_word(cur_q), .fold_hi(hi_q), .byte_addr(byte_addr), .wr_opcode(wr_op),
    .page_end(page_end));

  spi_ew_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n_s), .start(sh_start), .tx_word(sh_tx), .nbits(sh_nbits),
    .miso(spi_miso), .busy(sh_busy), .done(sh_done), .rx_bit(sh_rx),
    .sck(spi_sck), .mosi(spi_mosi));

  always_comb begin
    state_d  = state_q;  ret_d    = ret_q;    sent_d  = sent_q;
    hi_d     = hi_q;     err_d    = err_q;    cs_d    = cs_q;
    req_d    = req_q;    tries_d  = tries_q;  polls_d = polls_q;
    pcnt_d   = pcnt_q;   cur_d    = cur_q;    remain_d = remain_q;
    done_d   = 1'b0;     error_d  = 1'b0;
    sh_start = 1'b0;     sh_tx    = '0;       sh_nbits = 5'd8;
    take     = 1'b0;
    case (state_q)
      ST_IDLE: if (start_valid) begin
        if (req_bad) begin
          err_d   = 1'b1;
          state_d = ST_RELEASE;
        end else begin
          cur_d    = start_offset[OFF_W-1:0];
          remain_d = start_count;
          hi_d     = FOLD && req_hi;
          req_d    = 1'b1;
          tries_d  = '0;
          state_d  = ST_GRANT;
        end
      end
      ST_GRANT: begin
        if (bus_gnt) begin
          cs_d    = 1'b0;
          polls_d = '0;
          state_d = ST_POLL_OP;
        end else if (tries_q == TR_W'(GRANT_TRIES - 1)) begin
          err_d   = 1'b1;
          state_d = ST_RELEASE;
        end else begin
          tries_d = tries_q + TR_W'(1);
        end
      end
      ST_POLL_OP, ST_POLL_RD, ST_WREN, ST_WROP, ST_ADDR, ST_DATA: begin
        case (state_q)
          ST_POLL_OP: sh_tx = 16'(OP_RDSR);
          ST_WREN:    sh_tx = 16'(OP_WREN);
          ST_WROP:    sh_tx = 16'(wr_op);
          ST_ADDR:    begin sh_tx = 16'(byte_addr); sh_nbits = 5'(ADDR_BITS); end
          ST_DATA:    begin sh_tx = {word_data[7:0], word_data[15:8]}; sh_nbits = 5'd16; end
          default:    sh_tx = '0;
        endcase
        if (!sent_q) begin
          sh_start = 1'b1;
          sent_d   = 1'b1;
          take     = (state_q == ST_DATA);
        end else if (sh_done) begin
          sent_d = 1'b0;
          case (state_q)
            ST_POLL_OP: state_d = ST_POLL_RD;
            ST_POLL_RD: begin
              if (!sh_rx) begin
                ret_d = ST_WREN; cs_d = 1'b1; pcnt_d = '0; state_d = ST_PULSE;
              end else if (polls_q == PL_W'(READY_TRIES - 1)) begin
                err_d = 1'b1; state_d = ST_RELEASE;
              end else begin
                polls_d = polls_q + PL_W'(1);
                ret_d = ST_POLL_OP; cs_d = 1'b1; pcnt_d = '0; state_d = ST_PULSE;
              end
            end
            ST_WREN: begin
              ret_d = ST_WROP; cs_d = 1'b1; pcnt_d = '0; state_d = ST_PULSE;
            end
            ST_WROP: state_d = ST_ADDR;
            ST_ADDR: state_d = ST_DATA;
            default: begin
              remain_d = remain_q - CNT_W'(1);
              cur_d    = cur_q + OFF_W'(1);
              if (remain_q == CNT_W'(1)) begin
                state_d = ST_RELEASE;
              end else if (page_end) begin
                polls_d = '0;
                ret_d = ST_POLL_OP; cs_d = 1'b1; pcnt_d = '0; state_d = ST_PULSE;
              end
            end
          endcase
        end
      end
      ST_PULSE: begin
        if (pcnt_q == DV_W'(CLK_DIV - 1)) begin
          cs_d    = 1'b0;
          state_d = ret_q;
        end else begin
          pcnt_d = pcnt_q + DV_W'(1);
        end
      end
      ST_RELEASE: begin
        cs_d    = 1'b1;
        req_d   = 1'b0;
        done_d  = 1'b1;
        error_d = err_q;
        err_d   = 1'b0;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q  <= ST_IDLE;  ret_q   <= ST_IDLE;  sent_q  <= 1'b0;
      hi_q     <= 1'b0;     err_q   <= 1'b0;     cs_q    <= 1'b1;
      req_q    <= 1'b0;     done_q  <= 1'b0;     error_q <= 1'b0;
      tries_q  <= '0;       polls_q <= '0;       pcnt_q  <= '0;
      cur_q    <= '0;       remain_q <= '0;
    end else begin
      state_q  <= state_d;  ret_q   <= ret_d;    sent_q  <= sent_d;
      hi_q     <= hi_d;     err_q   <= err_d;    cs_q    <= cs_d;
      req_q    <= req_d;    done_q  <= done_d;   error_q <= error_d;
      tries_q  <= tries_d;  polls_q <= polls_d;  pcnt_q  <= pcnt_d;
      cur_q    <= cur_d;    remain_q <= remain_d;
    end
  end

  assign start_ready = (state_q == ST_IDLE);
  assign word_take   = take;
  assign bus_req     = req_q;
  assign spi_cs_n    = cs_q;
  assign done        = done_q;
  assign error       = error_q;
endmodule

// File: rtl/spi_ew_checker.sv
module spi_ew_checker (
  input logic clk,
  input logic rst_n,
  input logic spi_cs_n,
  input logic spi_sck,
  input logic spi_mosi,
  input logic bus_req,
  input logic done,
  input logic error,
  input logic word_take,
  input logic start_ready
);
  a_r8_sck_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> !spi_cs_n);

  a_r8_mosi_held_high_clk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

  a_r8_deselected_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> (!spi_sck && !spi_mosi));

  a_r1_select_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |-> spi_cs_n);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_error_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);

  a_r2_req_drop_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> done);

  a_r6_take_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    word_take |-> (!start_ready && bus_req));
endmodule

bind spi_eeprom_writer spi_ew_checker u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
  .spi_mosi(spi_mosi), .bus_req(bus_req), .done(done), .error(error),
  .word_take(word_take), .start_ready(start_ready));

// File: tb/spi_eeprom_writer_bench.sv
`timescale 1ns/1ps
module spi_eeprom_writer_bench;
  localparam int WS = 256, GT = 16, RT = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_valid = 1'b0;
  logic [8:0] start_offset = '0, start_count = '0;
  logic [15:0] word_data;
  logic word_take, start_ready, bus_req, spi_cs_n, spi_sck, spi_mosi, spi_miso, done, error;
  logic bus_gnt = 1'b0;

  int checks = 0, fails = 0;
  logic [15:0] words [256];
  int widx = 0; bit pend = 0;
  int gcnt = 0, gdelay = 0;

  logic [7:0] dev_mem [512];
  logic [7:0] exp_mem [512];
  logic [7:0] m_op = 8'h00, m_cur = 8'h00, exp_op = 8'h02;
  logic [8:0] m_addr = '0;
  logic [7:0] m_status;
  int m_bits = 0, m_busy = 0, write_busy = 0;
  bit m_wren = 0;
  int wr_cmds = 0, polls_seen = 0, wren_miss = 0, op_mis = 0, page_viol = 0, sck_out = 0;

  always #2 clk = ~clk;

  spi_eeprom_writer u_spi_eeprom_writer (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .start_offset(start_offset), .start_count(start_count), .word_data(word_data),
    .word_take(word_take), .bus_req(bus_req), .bus_gnt(bus_gnt), .spi_cs_n(spi_cs_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .done(done), .error(error));

  assign word_data = words[widx % 256];
  assign m_status  = {4'hA, 3'b000, (m_busy > 0)};
  assign spi_miso  = (m_op == 8'h05 && m_bits >= 8 && m_bits < 16) ? m_status[15 - m_bits] : 1'b0;

  always @(negedge clk) begin
    if (pend) begin widx++; pend = 0; end
    if (word_take) pend = 1;
    if (bus_req) gcnt++; else gcnt = 0;
    bus_gnt = bus_req && (gcnt > gdelay);
  end

  always @(negedge spi_cs_n) begin m_bits = 0; m_op = 8'h00; end

  always @(posedge spi_sck) begin
    if (spi_cs_n) sck_out++;
    else begin
      m_cur = {m_cur[6:0], spi_mosi};
      m_bits++;
      if (m_bits % 8 == 0) begin
        if (m_bits == 8) begin
          m_op = m_cur;
          if (m_cur == 8'h06) m_wren = 1;
          if ((m_cur & 8'hF7) == 8'h02) begin
            wr_cmds++;
            if (!m_wren) wren_miss++;
            if (m_cur != exp_op) op_mis++;
          end
        end else if ((m_op & 8'hF7) == 8'h02) begin
          if (m_bits == 16) m_addr = {m_op[3], m_cur};
          else begin
            if (m_bits > 24 && m_addr[3:0] == 4'h0) page_viol++;
            dev_mem[m_addr] = m_cur;
            m_addr = {m_addr[8], m_addr[7:0] + 8'd1};
          end
        end
      end
    end
  end

  always @(posedge spi_cs_n) begin
    if ((m_op & 8'hF7) == 8'h02) begin m_wren = 0; m_busy = write_busy; end
    else if (m_op == 8'h05 && m_bits >= 16) begin
      polls_seen++;
      if (m_busy > 0) m_busy--;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  function automatic int segments(input int off, input int cnt);
    int s = 1;
    for (int k = 1; k < cnt; k++) if (((off + k) % 8) == 0) s++;
    return s;
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // kind: 0 success, 1 bounds reject, 2 grant timeout, 3 ready timeout
  task automatic run(input int off, input int cnt, input int gd, input int rdy,
                     input int wb, input int kind);
    int n_done = 0, err_at_done = 0, seg, cyc = 0, wc0, pl0, mis = 0;
    bit saw_req = 0, saw_cs = 0;
    for (int i = 0; i < 256; i++) words[i] = 16'($urandom);
    widx = 0; gdelay = gd; m_busy = rdy; write_busy = wb;
    exp_op = (off >= 128) ? 8'h0A : 8'h02;
    wc0 = wr_cmds; pl0 = polls_seen; wren_miss = 0; op_mis = 0; page_viol = 0; sck_out = 0;
    @(negedge clk);
    start_offset = 9'(off); start_count = 9'(cnt); start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    while (n_done == 0 && cyc < 20000) begin
      if (bus_req) saw_req = 1;
      if (!spi_cs_n) saw_cs = 1;
      if (done) begin n_done++; err_at_done = error; end
      if (n_done == 0) begin @(negedge clk); cyc++; end
    end
    for (int i = 0; i < 3; i++) begin @(negedge clk); if (done) n_done++; end
    chk(n_done == 1, "R9 done pulse count", n_done, 1);
    chk(err_at_done == (kind != 0), "R9 error flag at done", err_at_done, kind != 0);
    chk(spi_cs_n && !bus_req, "R9 pins released", {spi_cs_n, bus_req}, 2);
    chk(sck_out == 0, "R8 clock while deselected", sck_out, 0);
    if (kind == 0) begin
      for (int k = 0; k < cnt; k++) begin
        int a = ((off >= 128) ? 256 : 0) + (((off + k) * 2) % 256);
        exp_mem[a]     = words[k][7:0];
        exp_mem[a + 1] = words[k][15:8];
      end
      seg = segments(off, cnt);
      chk(widx == cnt, "R6 words pulled", widx, cnt);
      chk(wr_cmds - wc0 == seg, "R7 write commands", wr_cmds - wc0, seg);
      chk(page_viol == 0, "R7 page crossing", page_viol, 0);
      chk(wren_miss == 0, "R4 write without enable", wren_miss, 0);
      chk(op_mis == 0, "R5 write opcode", op_mis, 0);
      chk(polls_seen - pl0 == (rdy + 1) + (seg - 1) * (wb + 1), "R3 status polls",
          polls_seen - pl0, (rdy + 1) + (seg - 1) * (wb + 1));
    end else if (kind == 1) begin
      chk(!saw_req && !saw_cs, "R1 bus untouched", {saw_req, saw_cs}, 0);
    end else if (kind == 2) begin
      chk(saw_req && !saw_cs, "R2 grant timeout", {saw_req, saw_cs}, 2);
    end else begin
      chk(polls_seen - pl0 == RT, "R3 ready limit polls", polls_seen - pl0, RT);
      chk(wr_cmds == wc0, "R3 no write after timeout", wr_cmds - wc0, 0);
    end
    for (int i = 0; i < 512; i++) if (dev_mem[i] !== exp_mem[i]) mis++;
    chk(mis == 0, "R5 R6 device contents", mis, 0);
    m_busy = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R9 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 512; i++) begin dev_mem[i] = 8'hFF; exp_mem[i] = 8'hFF; end
    repeat (3) @(negedge clk);
    chk(spi_cs_n && !spi_sck && !spi_mosi && !bus_req && !done && start_ready,
        "R10 reset state", {spi_cs_n, spi_sck, spi_mosi, bus_req, done, start_ready}, 6'b100001);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(spi_cs_n && !spi_sck && !bus_req && start_ready, "R10 after reset",
        {spi_cs_n, spi_sck, bus_req, start_ready}, 4'b1001);
    // directed corner cases
    run(0,   3, 0, 0, 0, 0);   // R5 R6 short burst at start
    run(7,   2, 1, 2, 1, 0);   // R7 split after first word
    run(128, 3, 0, 0, 0, 0);   // R5 ninth address bit
    run(120, 10, 2, 1, 2, 0);  // R5 R7 flag taken from start offset
    run(255, 1, 0, 0, 0, 0);   // R1 last word accepted
    run(250, 6, 0, 0, 0, 0);   // R1 run to device end
    run(0,   1, 0, 5, 0, 0);   // R3 ready on last allowed poll
    run(4,   2, 0, 6, 0, 3);   // R3 ready never reached
    run(9,   1, 15, 0, 0, 0);  // R2 grant on last try
    run(9,   1, 16, 0, 0, 2);  // R2 grant one try late
    run(256, 1, 0, 0, 0, 1);   // R1 offset at size
    run(0,   0, 0, 0, 0, 1);   // R1 zero count
    run(250, 7, 0, 0, 0, 1);   // R1 count past end
    run(300, 2, 0, 0, 0, 1);   // R1 offset far out
    // constrained random
    for (int t = 0; t < 20; t++) begin
      int off = $urandom % 256;
      int room = 256 - off;
      int cnt = 1 + ($urandom % ((room < 20) ? room : 20));
      run(off, cnt, $urandom % 4, $urandom % 3, $urandom % 3, 0);
    end
    summary();
    $finish;
  end
endmodule